// File: doc/BRIEF.md
# Lock-Protected Power Control Registers

This block is a small register file inside a hardware root of trust. It holds the clock-frequency and supply-voltage scaling settings and drives them to the clock and power logic. Every requester reaches it through one register bus carrying an address, write data, write and read strobes, and a privilege tag. The tag marks each request as coming from the trusted management controller or from an untrusted application core.

A lock flag guards a contiguous, inclusive window of security-critical registers. While the flag is set, no write lands inside that window, whoever sends it. Only the trusted controller can change the flag. Writes outside the window are open to every requester, and reads are open everywhere. Each refused write raises a one-cycle denial pulse and bumps a saturating violation counter that software can read back.

Top module: `pwr_lock_regs`

## Requirements
- R1: After reset the lock flag reads 1, the violation counter reads 0, `rsp_denied` is 0, `freq_sel` equals `FREQ_RST` (default 16'h0064) and `volt_sel` equals `VOLT_RST` (default 16'h0320). All other storage registers read 0.
- R2: The protected window spans `WIN_LO` through `WIN_HI` inclusive (defaults 2 and 5). While the lock flag is 1, a write to any address in it is refused from either kind of requester, and the target keeps its old value.
- R3: The lock flag is bit 0 of address 0. A write there from a request with `req_priv`=0 is refused and leaves the flag unchanged. A write with `req_priv`=1 loads `req_wdata[0]`, in both directions.
- R4: While the lock flag is 0, writes inside the protected window are accepted from any requester. A write is judged against the flag value held at the start of its cycle.
- R5: Writes to addresses above `WIN_HI` (scratch registers 6..15 by default) are accepted from any requester and are never refused.
- R6: A read strobe from any requester returns the addressed value on `rsp_rdata` one cycle later. Address 0 returns the lock flag in bit 0, and address 1 returns the violation counter zero-extended.
- R7: A refused write drives `rsp_denied` high for exactly the cycle after the request. An accepted write leaves it low.
- R8: Each refused write adds one to the 8-bit violation counter, which stops at 255.
- R9: `freq_sel` (address `WIN_LO`) and `volt_sel` (address `WIN_LO`+1) change only on an accepted write to their own address. They show the new value from the clock edge that accepts it.
- R10: The violation counter at address 1 is read-only. A write there from any requester changes nothing and is not refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_addr | input | AW | Register address |
| req_wdata | input | DW | Write data |
| req_we | input | 1 | Write strobe |
| req_re | input | 1 | Read strobe |
| req_priv | input | 1 | 1 = trusted management controller, 0 = untrusted core |
| rsp_rdata | output | DW | Read data, valid the cycle after `req_re` |
| rsp_denied | output | 1 | One-cycle pulse for a refused write |
| freq_sel | output | DW | Current clock-frequency setting |
| volt_sel | output | DW | Current voltage setting |

## Verification
Each result of this block is due one clock edge after its request: the denial pulse, the register update that reaches `freq_sel`/`volt_sel`, the counter increment and the read data. The bench drives a request on a falling edge and samples the outputs on the next falling edge, so exactly one rising edge separates stimulus from check. For the counter and for refused writes, a follow-up read is issued and checked one edge after that. The denial pulse is checked again on an idle cycle to confirm it lasts a single cycle.

// File: rtl/pwr_lock_regs.sv
module pwr_lock_regs #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 8,
  parameter logic [AW-1:0] WIN_LO = AW'(2),
  parameter logic [AW-1:0] WIN_HI = AW'(5),
  parameter logic [DW-1:0] FREQ_RST = DW'(16'h0064),
  parameter logic [DW-1:0] VOLT_RST = DW'(16'h0320)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_we,
  input  logic          req_re,
  input  logic          req_priv,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_denied,
  output logic [DW-1:0] freq_sel,
  output logic [DW-1:0] volt_sel
);

  localparam int unsigned NREG = 1 << AW;
  localparam int unsigned FIRST = 2;
  localparam logic [AW-1:0] A_LOCK = AW'(0);
  localparam logic [AW-1:0] A_CNT = AW'(1);
  localparam logic [AW-1:0] A_FREQ = WIN_LO;
  localparam logic [AW-1:0] A_VOLT = WIN_LO + AW'(1);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [DW-1:0] mem [FIRST:NREG-1];
  logic          lock_q;
  logic [CW-1:0] cnt_q;

  logic in_win, in_mem, wr_blocked, wr_ok;

  assign in_win     = (req_addr >= WIN_LO) && (req_addr <= WIN_HI);
  assign in_mem     = req_addr >= AW'(FIRST);
  assign wr_blocked = req_we && (((req_addr == A_LOCK) && !req_priv) || (in_win && lock_q));
  assign wr_ok      = req_we && !wr_blocked;

  function automatic logic [DW-1:0] rst_val(int unsigned idx);
    if (idx == int'(A_FREQ)) return FREQ_RST;
    if (idx == int'(A_VOLT)) return VOLT_RST;
    return '0;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int unsigned i = FIRST; i < NREG; i++) mem[i] <= rst_val(i);
    end else if (wr_ok && in_mem) begin
      mem[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b1;
    else if (wr_ok && req_addr == A_LOCK) lock_q <= req_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      rsp_denied <= 1'b0;
    end else begin
      rsp_denied <= wr_blocked;
      if (wr_blocked && cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (req_re) begin
      if (req_addr == A_LOCK)     rsp_rdata <= {{(DW-1){1'b0}}, lock_q};
      else if (req_addr == A_CNT) rsp_rdata <= {{(DW-CW){1'b0}}, cnt_q};
      else                        rsp_rdata <= mem[req_addr];
    end
  end

  assign freq_sel = mem[A_FREQ];
  assign volt_sel = mem[A_VOLT];

  p_locked_freq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_addr == A_FREQ && lock_q) |=> (freq_sel == $past(freq_sel)));

  p_locked_volt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_addr == A_VOLT && lock_q) |=> (volt_sel == $past(volt_sel)));

  p_lock_unpriv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !req_priv) |=> $stable(lock_q));

  p_open_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_addr > WIN_HI) |=> !rsp_denied);

  p_deny_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && !req_priv && req_addr == A_LOCK) |=> rsp_denied);

  p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (rsp_denied && cnt_q == $past(cnt_q) + CW'(1)));

  p_freq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_sel != $past(freq_sel)) |-> $past(req_we && req_addr == A_FREQ && !lock_q));

  p_volt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_sel != $past(volt_sel)) |-> $past(req_we && req_addr == A_VOLT && !lock_q));

  p_cnt_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_we && req_addr == A_CNT) |=> !rsp_denied);

endmodule

// File: tb/tb_pwr_lock_regs.sv
module tb_pwr_lock_regs;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 16;
  localparam logic [DW-1:0] FREQ_RST = 16'h0064;
  localparam logic [DW-1:0] VOLT_RST = 16'h0320;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_we = 1'b0;
  logic          req_re = 1'b0;
  logic          req_priv = 1'b0;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_denied;
  logic [DW-1:0] freq_sel;
  logic [DW-1:0] volt_sel;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_lock_regs #(.AW(AW), .DW(DW), .CW(8), .WIN_LO(4'd2), .WIN_HI(4'd5),
                  .FREQ_RST(FREQ_RST), .VOLT_RST(VOLT_RST)) dut (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_we(req_we), .req_re(req_re), .req_priv(req_priv),
    .rsp_rdata(rsp_rdata), .rsp_denied(rsp_denied),
    .freq_sel(freq_sel), .volt_sel(volt_sel));

  task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d, logic p, output logic den);
    @(negedge clk);
    req_addr = a; req_wdata = d; req_priv = p; req_we = 1'b1;
    @(negedge clk);
    den = rsp_denied;
    req_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic p, output logic [DW-1:0] q);
    @(negedge clk);
    req_addr = a; req_priv = p; req_re = 1'b1;
    @(negedge clk);
    q = rsp_rdata;
    req_re = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] q;
    chk("R1", "freq_sel", freq_sel, FREQ_RST);
    chk("R1", "volt_sel", volt_sel, VOLT_RST);
    chk("R1", "denied", {15'd0, rsp_denied}, 16'd0);
    rd(4'd0, 1'b0, q); chk("R1", "lock", q, 16'd1);
    rd(4'd1, 1'b0, q); chk("R1", "counter", q, 16'd0);
    rd(4'd9, 1'b0, q); chk("R1", "scratch", q, 16'd0);
  endtask

  task automatic t_locked_block();
    logic den; logic [DW-1:0] q;
    wr(4'd2, 16'h1234, 1'b0, den);
    chk("R7", "denied unpriv freq", {15'd0, den}, 16'd1);
    chk("R2", "freq kept", freq_sel, FREQ_RST);
    wr(4'd3, 16'h0100, 1'b1, den);
    chk("R2", "denied priv volt", {15'd0, den}, 16'd1);
    chk("R2", "volt kept", volt_sel, VOLT_RST);
    wr(4'd5, 16'hAAAA, 1'b0, den);
    chk("R2", "denied window top", {15'd0, den}, 16'd1);
    @(negedge clk);
    chk("R7", "pulse one cycle", {15'd0, rsp_denied}, 16'd0);
    rd(4'd5, 1'b0, q); chk("R2", "window top kept", q, 16'd0);
    rd(4'd1, 1'b0, q); chk("R8", "counter 3", q, 16'd3);
  endtask

  task automatic t_lock_unpriv();
    logic den; logic [DW-1:0] q;
    wr(4'd0, 16'h0000, 1'b0, den);
    chk("R3", "unpriv lock denied", {15'd0, den}, 16'd1);
    rd(4'd0, 1'b0, q); chk("R3", "lock still set", q, 16'd1);
  endtask

  task automatic t_open();
    logic den; logic [DW-1:0] q;
    wr(4'd6, 16'hBEEF, 1'b0, den);
    chk("R5", "scratch6 not denied", {15'd0, den}, 16'd0);
    chk("R9", "freq untouched", freq_sel, FREQ_RST);
    wr(4'd15, 16'hC0DE, 1'b1, den);
    chk("R5", "scratch15 not denied", {15'd0, den}, 16'd0);
    rd(4'd6, 1'b0, q); chk("R6", "scratch6 readback", q, 16'hBEEF);
    rd(4'd15, 1'b1, q); chk("R6", "scratch15 readback", q, 16'hC0DE);
  endtask

  task automatic t_unlock();
    logic den; logic [DW-1:0] q;
    wr(4'd0, 16'h0000, 1'b1, den);
    chk("R3", "priv unlock ok", {15'd0, den}, 16'd0);
    rd(4'd0, 1'b0, q); chk("R3", "lock cleared", q, 16'd0);
    wr(4'd2, 16'h0200, 1'b0, den);
    chk("R4", "unlocked freq ok", {15'd0, den}, 16'd0);
    chk("R9", "freq updated", freq_sel, 16'h0200);
    chk("R9", "volt untouched", volt_sel, VOLT_RST);
    wr(4'd5, 16'h5555, 1'b1, den);
    rd(4'd5, 1'b0, q); chk("R4", "window top written", q, 16'h5555);
    wr(4'd3, 16'h0300, 1'b0, den);
    chk("R9", "volt updated", volt_sel, 16'h0300);
  endtask

  task automatic t_relock();
    logic den; logic [DW-1:0] q;
    wr(4'd0, 16'h0001, 1'b1, den);
    rd(4'd0, 1'b0, q); chk("R3", "relocked", q, 16'd1);
    wr(4'd3, 16'h0999, 1'b0, den);
    chk("R2", "relock denies", {15'd0, den}, 16'd1);
    chk("R2", "volt kept after relock", volt_sel, 16'h0300);
    rd(4'd1, 1'b0, q); chk("R8", "counter 5", q, 16'd5);
  endtask

  task automatic t_cnt_ro();
    logic den; logic [DW-1:0] q;
    wr(4'd1, 16'h0000, 1'b1, den);
    chk("R10", "counter write not denied", {15'd0, den}, 16'd0);
    wr(4'd1, 16'h00FF, 1'b0, den);
    chk("R10", "unpriv counter write not denied", {15'd0, den}, 16'd0);
    rd(4'd1, 1'b0, q); chk("R10", "counter unchanged", q, 16'd5);
  endtask

  task automatic t_saturate();
    logic den; logic [DW-1:0] q;
    for (int i = 0; i < 260; i++) wr(4'd4, 16'h7777, 1'b0, den);
    chk("R8", "last denied", {15'd0, den}, 16'd1);
    rd(4'd1, 1'b0, q); chk("R8", "counter saturated", q, 16'd255);
    rd(4'd4, 1'b0, q); chk("R2", "reg4 kept", q, 16'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked_block();
    t_lock_unpriv();
    t_open();
    t_unlock();
    t_relock();
    t_cnt_ro();
    t_saturate();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule